// File: doc/BRIEF.md
# Latched Protection Fault Supervisor

This block sits between the analog protection comparators of a synchronous step-down converter and its gate-drive logic. Each clock it samples one flag per protection comparator. From those flags it produces three drive overrides and a registered fault code. The overrides are a top-switch inhibit, a forced bottom-switch-on and an all-off shutdown.

There are two kinds of over-current response. Over-current inside one switching cycle blanks the top switch for the rest of that cycle only. Over-current that persists, or feedback that stays low, is counted cycle by cycle at the switching strobe and ends in a latch-off. A sustained overvoltage is timed in clocks against a blanking window. When that window expires, the block enters a discharge mode in which the bottom switch follows a hysteretic window on the feedback.

The latched faults drop only on the clear input, which carries the enable reset or power-on reset. Over-temperature is different: it holds the stage off and releases by itself once the die has cooled.

Top module: `prot_fault_sup`

## Requirements
- R1: An `oc_i` high in a clock that is not a strobe clock raises `top_inhibit_o` from the next clock. It stays high until the clock after the next strobe, provided `oc_i` is low in that strobe clock. A switching cycle starts with a clock where `cyc_stb_i` is high.
- R2: When a strobe closes the 16th consecutive switching cycle that saw `oc_i`, the block latches all-off: `shutdown_o`=1, `top_inhibit_o`=1, `bot_force_o`=0. Any cycle without `oc_i` restarts the count, so 15 such cycles do not latch.
- R3: Eight consecutive switching cycles that saw `uv_i` latch all-off in the same way. Seven do not, and a cycle without `uv_i` restarts the count.
- R4: `ov_i` sampled high on OV_BLANK_CYC consecutive clocks latches the overvoltage fault. The default is 375 clocks, which is 1.5 us at 4 ns. One clock fewer does not latch.
- R5: In overvoltage the top switch is inhibited and `bot_force_o` starts at 1. The clock after `uvw_lo_i` is seen high, `bot_force_o` goes to 0 and stays there. It returns to 1 the clock after `uvw_hi_i` is seen high with `uvw_lo_i` low.
- R6: Latched over-current, undervoltage and overvoltage faults persist through any flag pattern. They clear only on a clock with `clr_i` high.
- R7: `temp_hot_i` forces all-off from the next clock. The block holds that state while `temp_cool_i` is low and releases the clock after `temp_cool_i` is seen high. `clr_i` has no effect on this state.
- R8: `status_o` is a registered code, valid one clock after the fault state it reports. The codes are 0 for none, 1 for over-current, 2 for undervoltage, 3 for overvoltage and 4 for thermal. When several faults are present the priority is OV, then OC, then UV, then thermal.
- R9: While overvoltage is latched, `shutdown_o` stays 0 even if other faults are present, so the bottom switch can still discharge the output.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous fault clear (enable reset / power-on reset) |
| cyc_stb_i | input | 1 | High on the first clock of each switching cycle |
| oc_i | input | 1 | Inductor over-current comparator |
| uv_i | input | 1 | Feedback below undervoltage trip |
| ov_i | input | 1 | Feedback above overvoltage trip |
| uvw_hi_i | input | 1 | Feedback above upper UV window threshold |
| uvw_lo_i | input | 1 | Feedback below lower UV window threshold |
| temp_hot_i | input | 1 | Die above shutdown temperature |
| temp_cool_i | input | 1 | Die below release temperature |
| top_inhibit_o | output | 1 | Keep the top switch off |
| bot_force_o | output | 1 | Force the bottom switch on |
| shutdown_o | output | 1 | Both switches off |
| status_o | output | 3 | Registered fault code |

## Verification
The over-current tests drive runs of 15 and 16 faulted switching cycles, with and without a clean cycle between runs. These runs show whether the counter length is right and whether a clean cycle really restarts the count. The undervoltage tests use the same shape of stimulus at 7 and 8 cycles. The overvoltage flag is held for exactly one clock short of the blanking window and then for exactly the window, which locates the latch edge. After the latch, the UV window flags are stepped through low, mid-band and high to show the hysteresis of the bottom drive. Mixed-fault patterns cover the remaining behaviour: an over-current latch followed by an overvoltage, and a hot die pulsed with clear. These show the overvoltage priority, the code priority, and the independence of the thermal state from clear.

// File: rtl/prot_fault_pkg.sv
package prot_fault_pkg;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_OC   = 3'd1,
    FC_UV   = 3'd2,
    FC_OV   = 3'd3,
    FC_HOT  = 3'd4
  } fault_code_e;

  // Priority encoder of latched fault state into the reported code.
  function automatic fault_code_e pick_code(input logic ov, input logic oc,
                                            input logic uv, input logic hot);
    if (ov)       return FC_OV;
    else if (oc)  return FC_OC;
    else if (uv)  return FC_UV;
    else if (hot) return FC_HOT;
    else          return FC_NONE;
  endfunction

endpackage

// File: rtl/cyc_run_cnt.sv
// Counts consecutive switching cycles in which an event flag was seen and
// latches a trip after LIMIT of them.
module cyc_run_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stb,
  input  logic evt,
  output logic hold_o,
  output logic trip_o
);
  localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic         hold_q;
  logic         trip_q;

  // Event seen during the running cycle; a strobe opens a new cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= 1'b0;
    else if (clr)    hold_q <= 1'b0;
    else if (stb)    hold_q <= evt;
    else             hold_q <= hold_q | evt;
  end

  // At each strobe the cycle just closed is judged.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (stb) begin
      if (!hold_q)            cnt_q  <= '0;
      else if (cnt_q == LAST) trip_q <= 1'b1;
      else                    cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign hold_o = hold_q;
  assign trip_o = trip_q;

  AST_TRIP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> $past(stb) && $past(hold_q)); // R2, R3
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stb && !evt && !clr |=> !hold_q); // R1

endmodule

// File: rtl/ov_blank_latch.sv
// Overvoltage fault: flag must stay high for BLANK consecutive clocks.
module ov_blank_latch #(
  parameter int BLANK = 375
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ov,
  output logic lat_o
);
  localparam int W = (BLANK > 2) ? $clog2(BLANK) : 1;
  localparam logic [W-1:0] LAST = W'(BLANK - 1);

  logic [W-1:0] run_q;
  logic         lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lat_q <= 1'b0;
    end else if (clr) begin
      run_q <= '0;
      lat_q <= 1'b0;
    end else if (!ov) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      lat_q <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign lat_o = lat_q;

  AST_OV_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_q) |-> $past(ov)); // R4
  AST_OV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q && !clr |=> lat_q); // R6

endmodule

// File: rtl/thermal_hyst.sv
// Self-releasing thermal state with a two-threshold hysteresis.
module thermal_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  input  logic cool_i,
  output logic hot_o
);
  logic hot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hot_q <= 1'b0;
    else if (hot_i)  hot_q <= 1'b1;
    else if (cool_i) hot_q <= 1'b0;
  end

  assign hot_o = hot_q;

  AST_HOT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    hot_i |=> hot_q); // R7
  AST_HOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    hot_q && !cool_i |=> hot_q); // R7

endmodule

// File: rtl/prot_fault_sup.sv
module prot_fault_sup
  import prot_fault_pkg::*;
#(
  parameter int OC_CYCLES    = 16,
  parameter int UV_CYCLES    = 8,
  parameter int OV_BLANK_CYC = 375
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       cyc_stb_i,
  input  logic       oc_i,
  input  logic       uv_i,
  input  logic       ov_i,
  input  logic       uvw_hi_i,
  input  logic       uvw_lo_i,
  input  logic       temp_hot_i,
  input  logic       temp_cool_i,
  output logic       top_inhibit_o,
  output logic       bot_force_o,
  output logic       shutdown_o,
  output logic [2:0] status_o
);
  localparam int N_RUN = 2;
  localparam int RUN_LIMIT [N_RUN] = '{OC_CYCLES, UV_CYCLES};

  // Named internal events for the checks below.
  logic [N_RUN-1:0] run_evt;
  logic [N_RUN-1:0] run_hold;
  logic [N_RUN-1:0] run_trip;
  logic oc_hold, oc_trip, uv_trip, ov_lat, die_hot;
  logic bot_on_q;
  logic [2:0] status_q;

  assign run_evt = {uv_i, oc_i};

  for (genvar g = 0; g < N_RUN; g++) begin : g_run
    cyc_run_cnt #(.LIMIT(RUN_LIMIT[g])) u_run (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_i),
      .stb   (cyc_stb_i),
      .evt   (run_evt[g]),
      .hold_o(run_hold[g]),
      .trip_o(run_trip[g])
    );
  end

  assign oc_hold = run_hold[0];
  assign oc_trip = run_trip[0];
  assign uv_trip = run_trip[1];

  ov_blank_latch #(.BLANK(OV_BLANK_CYC)) u_ov (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_i),
    .ov   (ov_i),
    .lat_o(ov_lat)
  );

  thermal_hyst u_hot (
    .clk   (clk),
    .rst_n (rst_n),
    .hot_i (temp_hot_i),
    .cool_i(temp_cool_i),
    .hot_o (die_hot)
  );

  // Bottom switch in overvoltage discharge: primed on, follows UV window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             bot_on_q <= 1'b1;
    else if (!ov_lat)       bot_on_q <= 1'b1;
    else if (uvw_lo_i)      bot_on_q <= 1'b0;
    else if (uvw_hi_i)      bot_on_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= FC_NONE;
    else        status_q <= pick_code(ov_lat, oc_trip, uv_trip, die_hot);
  end

  assign shutdown_o    = !ov_lat && (oc_trip || uv_trip || die_hot);
  assign top_inhibit_o = ov_lat || shutdown_o || oc_hold;
  assign bot_force_o   = ov_lat && bot_on_q;
  assign status_o      = status_q;

  AST_CBC_TOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oc_i && !cyc_stb_i && !clr_i |=> top_inhibit_o); // R1
  AST_OC_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip && !clr_i |=> oc_trip); // R6
  AST_UV_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    uv_trip && !clr_i |=> uv_trip); // R6
  AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |-> !bot_force_o && top_inhibit_o); // R2
  AST_BOT_OFF_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    ov_lat && uvw_lo_i && !clr_i |=> !bot_force_o); // R5
  AST_OV_NO_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_lat) |-> !shutdown_o && top_inhibit_o); // R9
  AST_OV_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_lat) |=> status_o == 3'd3); // R8

endmodule

// File: tb/prot_fault_sup_bench.sv
module prot_fault_sup_bench;
  localparam int OV_WIN = 375;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_i = 1'b0, cyc_stb_i = 1'b0, oc_i = 1'b0, uv_i = 1'b0, ov_i = 1'b0;
  logic uvw_hi_i = 1'b0, uvw_lo_i = 1'b0, temp_hot_i = 1'b0, temp_cool_i = 1'b0;
  logic top_inhibit_o, bot_force_o, shutdown_o;
  logic [2:0] status_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prot_fault_sup u_prot_fault_sup (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .cyc_stb_i(cyc_stb_i),
    .oc_i(oc_i), .uv_i(uv_i), .ov_i(ov_i), .uvw_hi_i(uvw_hi_i),
    .uvw_lo_i(uvw_lo_i), .temp_hot_i(temp_hot_i), .temp_cool_i(temp_cool_i),
    .top_inhibit_o(top_inhibit_o), .bot_force_o(bot_force_o),
    .shutdown_o(shutdown_o), .status_o(status_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clr();
    clr_i = 1'b1; step();
    clr_i = 1'b0; step();
  endtask

  // One switching cycle of four clocks; flags raised in its second clock.
  task automatic sw_cycle(input bit oc, input bit uv);
    cyc_stb_i = 1'b1; oc_i = 1'b0; uv_i = 1'b0; step();
    cyc_stb_i = 1'b0; oc_i = oc; uv_i = uv; step();
    oc_i = 1'b0; uv_i = 1'b0; step(2);
  endtask

  task automatic t_reset();
    chk("R10 top_inhibit", top_inhibit_o, 0);
    chk("R10 bot_force", bot_force_o, 0);
    chk("R10 shutdown", shutdown_o, 0);
    chk("R10 status", status_o, 0);
  endtask

  task automatic t_cbc();
    do_clr();
    cyc_stb_i = 1'b1; step();
    cyc_stb_i = 1'b0; oc_i = 1'b1; step();
    oc_i = 1'b0;
    chk("R1 inhibit after oc", top_inhibit_o, 1);
    step();
    chk("R1 inhibit held in cycle", top_inhibit_o, 1);
    chk("R1 no latch", shutdown_o, 0);
    cyc_stb_i = 1'b1; step();
    cyc_stb_i = 1'b0;
    chk("R1 inhibit released next cycle", top_inhibit_o, 0);
    step(2);
  endtask

  task automatic t_oc();
    do_clr();
    repeat (15) sw_cycle(1'b1, 1'b0);
    sw_cycle(1'b0, 1'b0);
    chk("R2 15 cycles no latch", shutdown_o, 0);
    repeat (15) sw_cycle(1'b1, 1'b0);
    sw_cycle(1'b0, 1'b0);
    chk("R2 broken run no latch", shutdown_o, 0);
    repeat (16) sw_cycle(1'b1, 1'b0);
    sw_cycle(1'b0, 1'b0);
    chk("R2 16 cycles shutdown", shutdown_o, 1);
    chk("R2 top off", top_inhibit_o, 1);
    chk("R2 bottom off", bot_force_o, 0);
    chk("R8 oc code", status_o, 1);
    repeat (5) sw_cycle(1'b0, 1'b0);
    uvw_hi_i = 1'b1; step(3); uvw_hi_i = 1'b0;
    chk("R6 oc latch persists", shutdown_o, 1);
    do_clr();
    chk("R6 clr releases", shutdown_o, 0);
    chk("R6 code cleared", status_o, 0);
  endtask

  task automatic t_uv();
    do_clr();
    repeat (7) sw_cycle(1'b0, 1'b1);
    sw_cycle(1'b0, 1'b0);
    chk("R3 7 cycles no latch", shutdown_o, 0);
    repeat (8) sw_cycle(1'b0, 1'b1);
    sw_cycle(1'b0, 1'b0);
    chk("R3 8 cycles shutdown", shutdown_o, 1);
    chk("R3 bottom off", bot_force_o, 0);
    chk("R8 uv code", status_o, 2);
    repeat (16) sw_cycle(1'b1, 1'b0);
    sw_cycle(1'b0, 1'b0);
    chk("R8 oc outranks uv", status_o, 1);
    do_clr();
    chk("R6 uv cleared", shutdown_o, 0);
  endtask

  task automatic t_ov();
    do_clr();
    ov_i = 1'b1; step(OV_WIN - 1);
    ov_i = 1'b0; step(2);
    chk("R4 short ov no latch", bot_force_o, 0);
    chk("R4 short ov code", status_o, 0);
    ov_i = 1'b1; step(OV_WIN);
    ov_i = 1'b0; step();
    chk("R4 ov latched bottom on", bot_force_o, 1);
    chk("R5 top off", top_inhibit_o, 1);
    chk("R9 no shutdown", shutdown_o, 0);
    chk("R8 ov code", status_o, 3);
    uvw_lo_i = 1'b1; step();
    chk("R5 below lower off", bot_force_o, 0);
    uvw_lo_i = 1'b0; step(3);
    chk("R5 mid band stays off", bot_force_o, 0);
    uvw_hi_i = 1'b1; step();
    chk("R5 above upper on", bot_force_o, 1);
    uvw_hi_i = 1'b0; step(3);
    chk("R5 mid band stays on", bot_force_o, 1);
    chk("R6 ov persists", top_inhibit_o, 1);
    do_clr();
    chk("R6 ov cleared", bot_force_o, 0);
    chk("R6 ov code cleared", status_o, 0);
  endtask

  task automatic t_prio();
    do_clr();
    repeat (16) sw_cycle(1'b1, 1'b0);
    sw_cycle(1'b0, 1'b0);
    chk("R9 oc latched first", shutdown_o, 1);
    ov_i = 1'b1; step(OV_WIN);
    ov_i = 1'b0; step();
    chk("R9 ov overrides all-off", shutdown_o, 0);
    chk("R9 bottom discharges", bot_force_o, 1);
    chk("R8 ov outranks oc", status_o, 3);
    do_clr();
    chk("R6 both cleared", shutdown_o, 0);
  endtask

  task automatic t_hot();
    do_clr();
    temp_hot_i = 1'b1; step();
    temp_hot_i = 1'b0;
    chk("R7 hot shutdown", shutdown_o, 1);
    step();
    chk("R8 hot code", status_o, 4);
    do_clr();
    chk("R7 clr no effect", shutdown_o, 1);
    step(5);
    chk("R7 held while warm", shutdown_o, 1);
    temp_cool_i = 1'b1; step();
    temp_cool_i = 1'b0;
    chk("R7 auto release", shutdown_o, 0);
    step();
    chk("R8 code after release", status_o, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_cbc();
    t_oc();
    t_uv();
    t_ov();
    t_prio();
    t_hot();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule